// File: doc/BRIEF.md
# Four-Channel PWM Motor Controller

This block is a memory-mapped peripheral behind an AXI4-Lite slave port that drives four brushed DC motor channels. Software programs one period value, which every channel shares. It also programs a separate duty value for each channel and a single control word. The control word packs an enable bit, a direction bit and a brake bit for every channel. A free-running counter steps from zero up to one less than the period. Each channel compares its duty against that common count to form its pulse train.

Each channel has three outputs: a PWM line, a direction line and a brake line. An asserted brake bit forces the PWM line low whatever the duty is. A channel whose enable bit is clear also holds its PWM line low. In a differential-drive vehicle, channels 0 and 1 form the left side and channels 2 and 3 form the right side. Steering comes from a difference in duty between the two sides. Setting every duty to zero stops the vehicle, and setting the brake bits brakes it actively. Every register can be read back.

Top module: `motor_pwm4`

## Requirements
- R1: After reset all registers read zero, all motor outputs are low, and no write response or read data is pending.
- R2: Register offsets are 0x00 for control, 0x04 for the period, and 0x08 + 4*n for the duty of channel n (n = 0..3). Every write response and read response carries OKAY (2'b00), and a written value reads back from the same offset.
- R3: In the control word, bits [3:0] are the channel enables, bits [7:4] the channel directions and bits [11:8] the channel brakes, with bit n+k*4 belonging to channel n. Bits [31:12] always read as zero.
- R4: A write updates only the bytes whose WSTRB bit is set; the other bytes keep their previous value.
- R5: The shared counter runs 0, 1, ..., period-1 and then wraps to 0. While the period is zero the counter stays at 0.
- R6: An enabled, unbraked channel drives its PWM line high exactly while counter < duty. Over any full period, duty 0 gives no high cycles and a duty at or above the period gives a constant high.
- R7: A channel whose enable bit is clear holds its PWM line low whatever its duty.
- R8: A channel whose brake bit is set drives its brake line high and its PWM line low whatever its duty and enable.
- R9: Each channel's direction line follows its direction bit in the control word.
- R10: Any write to the period register restarts the counter at 0 on the cycle after the write.
- R11: A write to an unmapped offset completes with OKAY and changes no register, and a read of an unmapped offset returns zero.
- R12: A write response stays valid until BREADY is seen, and no new write is accepted while it is pending. Read data stays valid and stable until RREADY is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awAddr | input | 8 | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| bResp | output | 2 | Write response, always OKAY |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| arAddr | input | 8 | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address accepted |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response, always OKAY |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data taken |
| motorPwm | output | 4 | PWM line per channel |
| motorDir | output | 4 | Direction line per channel |
| motorBrake | output | 4 | Brake line per channel |

## Verification
On every cycle, the assertions check the following:
- the counter stays below a nonzero period and sits at zero while the period is zero;
- the counter restarts after a period write;
- a braked or disabled channel never pulses, and a channel whose duty covers the period never drops;
- unmapped writes leave the registers untouched;
- pending responses hold their state.

Only the bench scenarios can show the rest. This covers the exact count of high cycles in a period for different duties, and the byte-lane merging and field placement of the control word as seen through readback. It also covers the phase of the PWM pattern right after the period is shrunk, and the mapping of each offset to its channel.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int BUS_W = 32;
  localparam int STRB_W = BUS_W / 8;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic              wrEn;
    logic              wrHit;
    logic [IDX_W-1:0]  wrIdx;
    logic [BUS_W-1:0]  wrData;
    logic [STRB_W-1:0] wrStrb;
    logic              rdEn;
    logic              rdHit;
    logic [IDX_W-1:0]  rdIdx;
  } busCmd_t;

  function automatic logic [BUS_W-1:0] mergeBytes(input logic [BUS_W-1:0] oldV,
                                                  input logic [BUS_W-1:0] newV,
                                                  input logic [STRB_W-1:0] strb);
    logic [BUS_W-1:0] res;
    for (int b = 0; b < STRB_W; b++) begin
      res[8*b +: 8] = strb[b] ? newV[8*b +: 8] : oldV[8*b +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/mpwm_axi_ctrl.sv
module mpwm_axi_ctrl
  import mpwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [BUS_W-1:0]  wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic              wValid,
  output logic              wReady,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic              rValid,
  input  logic              rReady,
  output busCmd_t           cmd
);
  localparam logic [IDX_W-1:0] NREG = IDX_W'(NUM_CH + 2);

  logic bValidQ, rValidQ, wrFire, rdFire;

  function automatic logic addrHit(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:IDX_W+2] == '0) && (a[IDX_W+1:2] < NREG);
  endfunction

  assign wrFire  = awValid && wValid && !bValidQ;
  assign rdFire  = arValid && !rValidQ;
  assign awReady = wrFire;
  assign wReady  = wrFire;
  assign arReady = !rValidQ;
  assign bValid  = bValidQ;
  assign rValid  = rValidQ;

  always_comb begin
    cmd.wrEn   = wrFire;
    cmd.wrHit  = addrHit(awAddr);
    cmd.wrIdx  = awAddr[IDX_W+1:2];
    cmd.wrData = wData;
    cmd.wrStrb = wStrb;
    cmd.rdEn   = rdFire;
    cmd.rdHit  = addrHit(arAddr);
    cmd.rdIdx  = arAddr[IDX_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValidQ <= 1'b0;
      rValidQ <= 1'b0;
    end else begin
      if (wrFire) bValidQ <= 1'b1;
      else if (bReady) bValidQ <= 1'b0;
      if (rdFire) rValidQ <= 1'b1;
      else if (rReady) rValidQ <= 1'b0;
    end
  end

  p_bvalid_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid);
  p_no_accept_pending_r12: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> !awReady);
  p_rvalid_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid);
endmodule

// File: rtl/mpwm_core.sv
module mpwm_core
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PWM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic              rValid,
  output logic [BUS_W-1:0]  rData,
  output logic [NUM_CH-1:0] motorPwm,
  output logic [NUM_CH-1:0] motorDir,
  output logic [NUM_CH-1:0] motorBrake
);
  localparam int CTRL_W = 3 * NUM_CH;

  logic [CTRL_W-1:0] ctrlReg;
  logic [PWM_W-1:0]  periodReg;
  logic [PWM_W-1:0]  dutyReg [NUM_CH];
  logic [PWM_W-1:0]  cnt;
  logic [BUS_W-1:0]  rDataQ, rdMux;
  logic              ctrlWr, periodWr, cntWrap;
  logic [NUM_CH-1:0] enBits;

  assign ctrlWr   = cmd.wrEn && cmd.wrHit && (cmd.wrIdx == IDX_W'(0));
  assign periodWr = cmd.wrEn && cmd.wrHit && (cmd.wrIdx == IDX_W'(1));
  assign cntWrap  = ({1'b0, cnt} + 1'b1) >= {1'b0, periodReg};
  assign enBits   = ctrlReg[NUM_CH-1:0];
  assign motorDir   = ctrlReg[2*NUM_CH-1:NUM_CH];
  assign motorBrake = ctrlReg[3*NUM_CH-1:2*NUM_CH];
  assign rData    = rDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      periodReg <= '0;
      for (int c = 0; c < NUM_CH; c++) dutyReg[c] <= '0;
    end else begin
      if (ctrlWr)
        ctrlReg <= CTRL_W'(mergeBytes(BUS_W'(ctrlReg), cmd.wrData, cmd.wrStrb));
      if (periodWr)
        periodReg <= PWM_W'(mergeBytes(BUS_W'(periodReg), cmd.wrData, cmd.wrStrb));
      for (int c = 0; c < NUM_CH; c++) begin
        if (cmd.wrEn && cmd.wrHit && cmd.wrIdx == IDX_W'(c + 2))
          dutyReg[c] <= PWM_W'(mergeBytes(BUS_W'(dutyReg[c]), cmd.wrData, cmd.wrStrb));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (periodWr)  cnt <= '0;
    else if (cntWrap)   cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  always_comb begin
    rdMux = '0;
    if (cmd.rdIdx == IDX_W'(0)) rdMux = BUS_W'(ctrlReg);
    else if (cmd.rdIdx == IDX_W'(1)) rdMux = BUS_W'(periodReg);
    for (int c = 0; c < NUM_CH; c++) begin
      if (cmd.rdIdx == IDX_W'(c + 2)) rdMux = BUS_W'(dutyReg[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rDataQ <= '0;
    else if (cmd.rdEn) rDataQ <= cmd.rdHit ? rdMux : '0;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic below;
    assign below = cnt < dutyReg[g];
    assign motorPwm[g] = enBits[g] && !motorBrake[g] && below;

    p_brake_blocks_pwm_r8: assert property (@(posedge clk) disable iff (!rstN)
      motorBrake[g] |-> !motorPwm[g]);
    p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      !enBits[g] |-> !motorPwm[g]);
    p_full_duty_high_r6: assert property (@(posedge clk) disable iff (!rstN)
      enBits[g] && !motorBrake[g] && periodReg != '0 && dutyReg[g] >= periodReg
      |-> motorPwm[g]);
  end

  p_cnt_below_period_r5: assert property (@(posedge clk) disable iff (!rstN)
    periodReg != '0 |-> cnt < periodReg);
  p_cnt_zero_period_r5: assert property (@(posedge clk) disable iff (!rstN)
    periodReg == '0 |=> cnt == '0);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    periodWr |=> cnt == '0);
  p_unmapped_no_effect_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn && !cmd.wrHit |=> $stable(ctrlReg) && $stable(periodReg));
  p_rdata_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    rValid && $past(rValid) |-> $stable(rDataQ));
endmodule

// File: rtl/motor_pwm4.sv
module motor_pwm4
  import mpwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 4,
  parameter int PWM_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [BUS_W-1:0]  wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic              wValid,
  output logic              wReady,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [BUS_W-1:0]  rData,
  output logic [1:0]        rResp,
  output logic              rValid,
  input  logic              rReady,
  output logic [NUM_CH-1:0] motorPwm,
  output logic [NUM_CH-1:0] motorDir,
  output logic [NUM_CH-1:0] motorBrake
);
  busCmd_t cmd;

  assign bResp = 2'b00;
  assign rResp = 2'b00;

  mpwm_axi_ctrl #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rValid(rValid), .rReady(rReady),
    .cmd(cmd)
  );

  mpwm_core #(.NUM_CH(NUM_CH), .PWM_W(PWM_W)) u_core (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rValid(rValid), .rData(rData),
    .motorPwm(motorPwm), .motorDir(motorDir), .motorBrake(motorBrake)
  );

  p_okay_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bValid |-> bResp == 2'b00) and (rValid |-> rResp == 2'b00));
endmodule

// File: tb/motor_pwm4_tb.sv
module motor_pwm4_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  awAddr = '0, arAddr = '0;
  logic        awValid = 1'b0, wValid = 1'b0, arValid = 1'b0;
  logic        bReady = 1'b1, rReady = 1'b1;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = '0;
  logic        awReady, wReady, bValid, arReady, rValid;
  logic [1:0]  bResp, rResp;
  logic [31:0] rData;
  logic [3:0]  motorPwm, motorDir, motorBrake;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  motor_pwm4 u_dut (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .motorPwm(motorPwm), .motorDir(motorDir), .motorBrake(motorBrake)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and write responses
  always @(negedge clk) begin
    if (rstN && rValid && rReady) begin
      if (expQ.size() == 0) check(0, "R2 unexpected read data", rData, 32'hx);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rData == e && rResp == 2'b00, t, rData, e);
      end
    end
    if (rstN && bValid && bReady) check(bResp == 2'b00, "R2 write response OKAY", 32'(bResp), 0);
  end

  task automatic axiWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    awAddr = a; wData = d; wStrb = s; awValid = 1'b1; wValid = 1'b1;
    #1;
    while (!awReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    awValid = 1'b0; wValid = 1'b0;
  endtask

  task automatic axiRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    arAddr = a; arValid = 1'b1;
    #1;
    while (!arReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    arValid = 1'b0;
  endtask

  task automatic countHighs(input int ch, input int n, input int exp, input string tag);
    int highs = 0;
    for (int k = 0; k < n; k++) begin
      if (motorPwm[ch]) highs++;
      @(negedge clk);
    end
    check(highs == exp, tag, 32'(highs), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(motorPwm == 0 && motorDir == 0 && motorBrake == 0, "R1 outputs low after reset",
          {20'h0, motorPwm, motorDir, motorBrake}, 0);
    check(!bValid && !rValid, "R1 no pending response", {30'h0, bValid, rValid}, 0);
    axiRead(8'h00, 32'h0, "R1 control reads zero");
    axiRead(8'h04, 32'h0, "R1 period reads zero");
    axiRead(8'h14, 32'h0, "R1 duty3 reads zero");

    // R4 byte lane: only byte 1 written -> brake field bits [11:8]
    axiWrite(8'h00, 32'hFFFF_FFFF, 4'b0010);
    axiRead(8'h00, 32'h0000_0F00, "R4 R3 byte-1 strobe into control");
    check(motorBrake == 4'hF && motorPwm == 0, "R8 brake lines follow bits [11:8]",
          {24'h0, motorBrake, motorPwm}, 32'hF0);
    // R3 full write, upper bits read zero
    axiWrite(8'h00, 32'hFFFF_FFFF, 4'hF);
    axiRead(8'h00, 32'h0000_0FFF, "R3 control bits [31:12] read zero");
    // R4 period partial write
    axiWrite(8'h04, 32'h1234_5678, 4'b0101);
    axiRead(8'h04, 32'h0034_0078, "R4 period bytes 0 and 2 only");
    // R2 duty offsets
    axiWrite(8'h08, 32'h0000_0003, 4'hF);
    axiWrite(8'h0C, 32'h0000_0019, 4'hF);
    axiWrite(8'h10, 32'h0000_0005, 4'hF);
    axiWrite(8'h14, 32'h0000_0000, 4'hF);
    axiRead(8'h08, 32'd3, "R2 duty0 at 0x08");
    axiRead(8'h0C, 32'd25, "R2 duty1 at 0x0C");
    axiRead(8'h10, 32'd5, "R2 duty2 at 0x10");
    axiRead(8'h14, 32'd0, "R2 duty3 at 0x14");
    // R11 unmapped writes
    axiWrite(8'h18, 32'hDEAD_BEEF, 4'hF);
    axiWrite(8'h40, 32'hDEAD_BEEF, 4'hF);
    axiRead(8'h00, 32'h0000_0FFF, "R11 control unchanged by unmapped write");
    axiRead(8'h04, 32'h0034_0078, "R11 period unchanged by unmapped write");
    axiRead(8'h08, 32'd3, "R11 duty0 unchanged by unmapped write");
    axiRead(8'h18, 32'h0, "R11 unmapped read returns zero");

    // PWM: period 10; en=1111 dir=0101 brake=0100
    axiWrite(8'h04, 32'd10, 4'hF);
    axiWrite(8'h00, 32'h0000_045F, 4'hF);
    check(motorDir == 4'b0101, "R9 direction lines", 32'(motorDir), 32'h5);
    check(motorBrake == 4'b0100, "R8 brake line ch2", 32'(motorBrake), 32'h4);
    countHighs(0, 10, 3, "R6 R5 duty 3 of period 10");
    countHighs(1, 10, 10, "R6 duty above period constant high");
    countHighs(2, 10, 0, "R8 braked channel stays low");
    countHighs(3, 10, 0, "R6 duty zero stays low");
    // ch3 disabled with nonzero duty; ch2 unbraked
    axiWrite(8'h14, 32'd6, 4'hF);
    axiWrite(8'h00, 32'h0000_00A7, 4'hF);
    check(motorDir == 4'b1010 && motorBrake == 0, "R9 direction lines updated",
          {24'h0, motorDir, motorBrake}, 32'hA0);
    countHighs(3, 10, 0, "R7 disabled channel stays low");
    countHighs(2, 10, 5, "R6 duty 5 of period 10");
    // R5 period zero: counter holds at 0
    axiWrite(8'h04, 32'd0, 4'hF);
    countHighs(0, 12, 12, "R5 zero period holds counter, duty 3 high");
    // R10 restart on period write
    axiWrite(8'h04, 32'd100, 4'hF);
    axiWrite(8'h08, 32'd4, 4'hF);
    repeat (37) @(negedge clk);
    axiWrite(8'h04, 32'd8, 4'hF);
    for (int k = 0; k < 8; k++) begin
      check(motorPwm[0] == (k < 4), "R10 counter restarts after period write",
            32'(motorPwm[0]), 32'(k < 4));
      @(negedge clk);
    end

    // R12 write response held without BREADY
    bReady = 1'b0;
    axiWrite(8'h14, 32'd2, 4'hF);
    repeat (3) @(negedge clk);
    check(bValid, "R12 bValid held while bReady low", 32'(bValid), 1);
    awAddr = 8'h14; wData = 32'd7; wStrb = 4'hF; awValid = 1'b1; wValid = 1'b1;
    #1;
    check(!awReady, "R12 no write accepted while response pending", 32'(awReady), 0);
    awValid = 1'b0; wValid = 1'b0;
    @(negedge clk);
    bReady = 1'b1;
    @(negedge clk);
    check(!bValid, "R12 bValid drops after bReady", 32'(bValid), 0);
    // R12 read data held without RREADY
    rReady = 1'b0;
    axiRead(8'h14, 32'd2, "R12 held read data");
    repeat (3) @(negedge clk);
    check(rValid && rData == 32'd2, "R12 rValid and data held while rReady low", rData, 32'd2);
    rReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!rValid, "R12 rValid drops after rReady", 32'(rValid), 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all expected reads returned", 32'(expQ.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule